// File: doc/BRIEF.md
# Three-Stage Pipeline Control Sequencer

This block steers an in-order fetch, decode and execute pipeline. Each cycle the datapath reports the class of the instruction held in the decode slot. The sequencer answers with the control that moves the pipeline: when to fetch, when decode hands its instruction to execute, which execute sub-step is active, and when a result is written back or memory is touched. Register file, ALU, shifter and memory are outside; they only consume these strobes.

Simple ALU work finishes in one execute cycle. Stores take two execute cycles, and loads and branches take three. While a load or store sits in a non-final phase, fetch and decode hold their contents and the program counter does not move. A branch is always taken. In its first execute cycle the sequencer raises a squash and selects the branch target for the program counter. The instruction in decode and the one fetched in that same cycle are dropped and never reach execute. Fetch then restarts at the target, and the target instruction executes right after the branch.

Top module: `pseq_ctrl`

## Requirements
- R1: From reset the pipeline is empty. In the first cycle after reset release `fetch_en`=1, `dec_adv`=0 and the phase is idle. In the second cycle `dec_adv`=1. The first non-idle phase appears in the third cycle.
- R2: An ALU-class instruction (class code 0) spends exactly one execute cycle in phase ALU (code 1), with `wb_en`=1, `fetch_en`=1 and `dec_adv`=1.
- R3: A store (class code 1) runs phase ADDR (code 2) and then phase XFER (code 3). `mem_en` is 1 only in XFER. Nothing is written back.
- R4: A load (class code 2) runs ADDR (2), then XFER (3) with `mem_en`=1, then MOVE (code 4) with `wb_en`=1.
- R5: A branch (class code 3) runs TGT (code 5), then LINK (code 6) with `wb_en`=1, then ADJ (code 7).
- R6: While a valid instruction waits in decode and execute is in a non-final load or store phase, `fetch_en`=0 and `dec_adv`=0.
- R7: In the TGT cycle `flush`=1, `pc_sel`=1 and `fetch_en`=1. The two wrong-path instructions never execute, and the next instruction executed is the one at the target.
- R8: In the final phase of every class, `dec_adv`=1, so execute is kept busy every cycle once it is filled.
- R9: Phase codes are IDLE=0, ALU=1, ADDR=2, XFER=3, MOVE=4, TGT=5, LINK=6, ADJ=7, and class codes are ALU=0, STORE=1, LOAD=2, BRANCH=3.
- R10: An idle or bubble execute slot drives `wb_en`=0 and `mem_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_class | input | 2 | Class of the instruction in the decode slot |
| fetch_en | output | 1 | Fetch an instruction this cycle |
| dec_adv | output | 1 | Decode hands its instruction to execute at the edge |
| ex_phase | output | 3 | Current execute sub-step code |
| flush | output | 1 | Squash the instructions younger than a taken branch |
| pc_sel | output | 1 | 1: next PC is the branch target, 0: sequential |
| wb_en | output | 1 | Register write-back strobe |
| mem_en | output | 1 | Data memory access strobe |

## Verification
Every output is decoded from registered state, so the response to an instruction class shows up in the cycle after `dec_adv` takes it. Each following phase lasts one cycle. A branch target executes four cycles after the branch was taken into execute. The bench models the instruction memory and program counter as a stub and walks the same program path ahead of time. It pushes one expected output vector per execute cycle into a queue. It then compares one popped vector at each falling edge, starting in the third cycle after reset release, so that every vector is matched to the cycle in which it is due.

// File: rtl/pseq_pkg.sv
// Shared encodings and phase-sequencing helpers for the pipeline sequencer.
// Assumes a fixed phase recipe per instruction class (R9 encodings).
package pseq_pkg;
    localparam int CLS_W = 2;
    localparam int PH_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU    = 2'd0,
        CL_STORE  = 2'd1,
        CL_LOAD   = 2'd2,
        CL_BRANCH = 2'd3
    } icls_e;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE = 3'd0,
        PH_ALU  = 3'd1,
        PH_ADDR = 3'd2,
        PH_XFER = 3'd3,
        PH_MOVE = 3'd4,
        PH_TGT  = 3'd5,
        PH_LINK = 3'd6,
        PH_ADJ  = 3'd7
    } xph_e;

    // Entry phase for an instruction class.
    function automatic xph_e entry_phase(icls_e c);
        case (c)
            CL_ALU:    return PH_ALU;
            CL_STORE:  return PH_ADDR;
            CL_LOAD:   return PH_ADDR;
            default:   return PH_TGT;
        endcase
    endfunction

    // True when the phase is the last one of its class.
    function automatic logic is_last(xph_e p, icls_e c);
        case (p)
            PH_ALU, PH_MOVE, PH_ADJ: return 1'b1;
            PH_XFER:                 return (c == CL_STORE);
            default:                 return 1'b0;
        endcase
    endfunction

    // Successor of a non-final phase.
    function automatic xph_e next_phase(xph_e p);
        case (p)
            PH_ADDR: return PH_XFER;
            PH_XFER: return PH_MOVE;
            PH_TGT:  return PH_LINK;
            PH_LINK: return PH_ADJ;
            default: return PH_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/pseq_exec.sv
// Execute-stage sequencer: holds the class and current phase of the
// instruction in execute. Assumes load_en only when the stage is free.
module pseq_exec
    import pseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_en,
    input  icls_e new_cls,
    output xph_e  phase,
    output logic  ex_free,
    output logic  in_tgt
);
    icls_e cls_q;
    xph_e  ph_q;

    // Stage is free when empty or finishing its last phase.
    always_comb begin
        ex_free = (ph_q == PH_IDLE) || is_last(ph_q, cls_q);
        in_tgt  = (ph_q == PH_TGT);
        phase   = ph_q;
    end

    // Step through the phase recipe or accept a new instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cls_q <= CL_ALU;
        end else if (!ex_free) begin
            ph_q  <= next_phase(ph_q);
        end else if (load_en) begin
            ph_q  <= entry_phase(new_cls);
            cls_q <= new_cls;
        end else begin
            ph_q  <= PH_IDLE;
        end
    end
endmodule

// File: rtl/pseq_dslot.sv
// Decode-slot occupancy: tracks whether decode holds a live instruction.
// Assumes squash has priority over a fill in the same cycle.
module pseq_dslot (
    input  logic clk,
    input  logic rst_n,
    input  logic squash,
    input  logic fill,
    output logic occupied
);
    // Squash empties the slot, a fetch fills it, otherwise it holds.
    always_ff @(posedge clk) begin
        if (!rst_n)      occupied <= 1'b0;
        else if (squash) occupied <= 1'b0;
        else if (fill)   occupied <= 1'b1;
    end
endmodule

// File: rtl/pseq_hazard.sv
// Stall and squash decision logic between decode and execute.
// Purely combinational; assumes registered inputs from the stage modules.
module pseq_hazard (
    input  logic dec_vld,
    input  logic ex_free,
    input  logic in_tgt,
    output logic fetch_en,
    output logic dec_adv,
    output logic flush,
    output logic pc_sel
);
    // Hold fetch/decode only when a waiting instruction cannot move on.
    always_comb begin
        fetch_en = in_tgt || ex_free || !dec_vld;
        dec_adv  = dec_vld && ex_free;
        flush    = in_tgt;
        pc_sel   = in_tgt;
    end
endmodule

// File: rtl/pseq_ctrl.sv
// Top of the three-stage pipeline control sequencer. Assumes the datapath
// presents the decode-slot class on dec_class and that branches are taken.
module pseq_ctrl
    import pseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLS_W-1:0] dec_class,
    output logic             fetch_en,
    output logic             dec_adv,
    output logic [PH_W-1:0]  ex_phase,
    output logic             flush,
    output logic             pc_sel,
    output logic             wb_en,
    output logic             mem_en
);
    logic dec_vld;
    logic ex_free;
    logic in_tgt;
    xph_e ph;

    pseq_dslot u_dslot (
        .clk      (clk),
        .rst_n    (rst_n),
        .squash   (flush),
        .fill     (fetch_en),
        .occupied (dec_vld)
    );

    pseq_exec u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (dec_adv),
        .new_cls (icls_e'(dec_class)),
        .phase   (ph),
        .ex_free (ex_free),
        .in_tgt  (in_tgt)
    );

    pseq_hazard u_haz (
        .dec_vld  (dec_vld),
        .ex_free  (ex_free),
        .in_tgt   (in_tgt),
        .fetch_en (fetch_en),
        .dec_adv  (dec_adv),
        .flush    (flush),
        .pc_sel   (pc_sel)
    );

    // Decode datapath strobes from the active phase.
    always_comb begin
        ex_phase = ph;
        wb_en    = (ph == PH_ALU) || (ph == PH_MOVE) || (ph == PH_LINK);
        mem_en   = (ph == PH_XFER);
    end
endmodule

// File: rtl/pseq_ctrl_chk.sv
// Protocol checker for pseq_ctrl, bound to every instance of the top.
module pseq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ex_phase,
    input logic       fetch_en,
    input logic       dec_adv,
    input logic       flush,
    input logic       wb_en,
    input logic       mem_en
);
    a_r3_xfer_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_phase == 3'd3) |-> ($past(ex_phase) == 3'd2));

    a_r4_move_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_phase == 3'd4) |-> ($past(ex_phase) == 3'd3));

    a_r5_link_after_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_phase == 3'd6) |-> ($past(ex_phase) == 3'd5));

    a_r5_adj_after_link: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_phase == 3'd7) |-> ($past(ex_phase) == 3'd6));

    a_r6_addr_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_phase == 3'd2) |-> !dec_adv);

    a_r7_flush_then_link: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ex_phase == 3'd6));

    a_r2_alu_keeps_fetching: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_phase == 3'd1) |-> fetch_en);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_phase == 3'd0) |-> (!wb_en && !mem_en));
endmodule

bind pseq_ctrl pseq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ex_phase (ex_phase),
    .fetch_en (fetch_en),
    .dec_adv  (dec_adv),
    .flush    (flush),
    .wb_en    (wb_en),
    .mem_en   (mem_en)
);

// File: tb/tb_pseq_ctrl.sv
module tb_pseq_ctrl;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dec_class;
    logic       fetch_en, dec_adv, flush, pc_sel, wb_en, mem_en;
    logic [2:0] ex_phase;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Instruction memory stub: class and branch target per address.
    logic [1:0] prog_cls [0:31];
    logic [4:0] prog_tgt [0:31];
    logic [4:0] pc;
    logic [1:0] d_cls;
    logic [4:0] d_tgt, ex_tgt;

    // Expected vector: {phase, wb, mem, fetch_en, dec_adv, flush, pc_sel}
    logic [8:0] exp_q [$];

    pseq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dec_class(dec_class),
        .fetch_en(fetch_en), .dec_adv(dec_adv), .ex_phase(ex_phase),
        .flush(flush), .pc_sel(pc_sel), .wb_en(wb_en), .mem_en(mem_en)
    );

    always #(PERIOD/2) clk = ~clk;

    assign dec_class = d_cls;

    // Datapath stub: PC, decode register and target latch.
    always @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; d_cls <= '0; d_tgt <= '0; ex_tgt <= '0;
        end else begin
            if (fetch_en) begin
                d_cls <= prog_cls[pc];
                d_tgt <= prog_tgt[pc];
            end
            if (dec_adv) ex_tgt <= d_tgt;
            if (pc_sel)        pc <= ex_tgt;
            else if (fetch_en) pc <= pc + 5'd1;
        end
    end

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s t=%0t got=%b exp=%b", req, $time, got, exp);
        end
    endtask

    task automatic push(input logic [2:0] ph, input logic wb, input logic mem,
                        input logic fe, input logic da, input logic fl, input logic ps);
        exp_q.push_back({ph, wb, mem, fe, da, fl, ps});
    endtask

    // Driver: walk the taken path and queue the due output vectors.
    task automatic build_expect(input int n_instr);
        int idx = 0;
        for (int n = 0; n < n_instr; n++) begin
            case (prog_cls[idx])
                2'd0: begin push(3'd1,1,0,1,1,0,0); idx = (idx + 1) % 32; end      // R2
                2'd1: begin push(3'd2,0,0,0,0,0,0); push(3'd3,0,1,1,1,0,0);       // R3 R6
                            idx = (idx + 1) % 32; end
                2'd2: begin push(3'd2,0,0,0,0,0,0); push(3'd3,0,1,0,0,0,0);       // R4 R6
                            push(3'd4,1,0,1,1,0,0); idx = (idx + 1) % 32; end
                default: begin push(3'd5,0,0,1,0,1,1); push(3'd6,1,0,1,0,0,0);    // R5 R7
                               push(3'd7,0,0,1,1,0,0); idx = int'(prog_tgt[idx]); end
            endcase
        end
    endtask

    function automatic string req_of(input logic [2:0] ph);
        case (ph)
            3'd1: return "R2 R8";
            3'd2: return "R6";
            3'd3: return "R3";
            3'd4: return "R4 R8";
            3'd5: return "R7";
            3'd6: return "R5";
            3'd7: return "R5 R8";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [8:0] observed();
        return {ex_phase, wb_en, mem_en, fetch_en, dec_adv, flush, pc_sel};
    endfunction

    // Watchdog: a hung run is one failed check.
    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus and monitor.
    initial begin
        for (int i = 0; i < 32; i++) begin prog_cls[i] = 2'd0; prog_tgt[i] = 5'd0; end
        prog_cls[1]  = 2'd1;
        prog_cls[2]  = 2'd2;
        prog_cls[4]  = 2'd3; prog_tgt[4]  = 5'd10;
        prog_cls[5]  = 2'd2;                       // wrong path
        prog_cls[6]  = 2'd1;                       // wrong path
        prog_cls[10] = 2'd2;
        prog_cls[11] = 2'd3; prog_tgt[11] = 5'd20;
        prog_cls[12] = 2'd3; prog_tgt[12] = 5'd0;  // wrong path
        prog_cls[13] = 2'd2;                       // wrong path
        prog_cls[20] = 2'd1;
        prog_cls[21] = 2'd1;
        prog_cls[22] = 2'd2;
        prog_cls[23] = 2'd3; prog_tgt[23] = 5'd30;
        prog_cls[30] = 2'd3; prog_tgt[30] = 5'd0;  // branch landing on a branch
        prog_cls[31] = 2'd2;                       // wrong path
        build_expect(40);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 R10: first cycle after release, empty pipe fetching.
        check("R1 R10", observed(), {3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0});
        @(negedge clk);
        // R1: decode holds the first instruction and hands it on.
        check("R1 R10", observed(), {3'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0});
        while (exp_q.size() > 0) begin
            logic [8:0] e;
            @(negedge clk);
            e = exp_q.pop_front();
            check(req_of(e[8:6]), observed(), e);   // R9 codes in vector
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule